// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing skeleton of a raster display: a display-enable window, a horizontal sync pulse, a vertical sync pulse, a field indicator for interlaced modes and a vertical-blank interrupt. Software sets up all of them through a small memory-mapped register bus. Once the run bit is set, a pixel counter advances every clock. A line counter advances each time the pixel counter wraps. The outputs are decoded from the two counter values against the programmed positions.

The horizontal and vertical fields do not share one encoding. Totals and active extents are stored minus one. The horizontal sync start is stored minus one, while the horizontal sync end is a raw position. Both vertical sync positions are raw. Each sync has its own polarity bit. The vertical-blank status bit is cleared by writing one to it. A separate output-drive enable can silence the outputs while the counters keep running.

Top module: `raster_timing_gen`

## Requirements
- R1: Registers: address 0 control (bit0 run, bit1 horizontal sync negative, bit2 vertical sync negative, bit3 interlace, bit4 interrupt enable, bit5 vertical-blank status), address 1 output drive (bit0), address 2 horizontal extents, address 3 horizontal sync, address 4 vertical extents, address 5 vertical sync. Each timing register holds a 12-bit field at bits [11:0] and a second at [27:16]. Written fields read back, and every other bit reads zero.
- R2: The low field of address 2 holds the pixels per line minus one. A line lasts exactly that many plus one clocks, and the pixel count starts at 0 on the cycle after run is written.
- R3: The display enable is high for pixels 0 up to the high field of address 2 (active minus one), on lines 0 up to the high field of address 4 (active lines minus one). The low field of address 4 is the line total minus one.
- R4: Horizontal sync is active on pixels from (low field of address 3) + 1 up to, but not including, the high field of address 3.
- R5: Vertical sync is active on lines from the low field of address 5 up to, but not including, its high field. Both values are raw line numbers.
- R6: When a polarity bit is clear, that sync is high when active. When the bit is set, the sync is inverted, so it idles high and goes low when active.
- R7: The status bit sets on the first line after the last active line, whatever the interrupt enable. The interrupt output equals status AND enable.
- R8: A control write with bit5 set clears the status. A write with bit5 clear leaves it unchanged.
- R9: With run clear, both counters are held at zero, the status cannot set, display enable is low and each sync sits at its inactive level.
- R10: With output drive clear, display enable is low and the syncs sit at their inactive level, while the counters and status keep running.
- R11: With interlace and run set, the field output toggles at the end of every frame. With interlace clear, it is 0.
- R12: After reset, all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| de_o | output | 1 | Display enable |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| field_o | output | 1 | Interlace field indicator |
| irq_o | output | 1 | Vertical-blank interrupt |

## Verification
The assertions check several rules on every cycle. The counters hold at zero while stopped and step by one between wraps. The status bit follows its set and write-one-to-clear events. The outputs stay idle when stopped, and display enable never appears without output drive. The field toggles at each frame end in interlaced mode. Only the bench scenarios can show that each programmed position lands on the exact pixel or line under the mixed minus-one encoding, across two different timings and both polarities. The same holds for the status setting on the right cycle, register readback, and the interrupt gating.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned POS_W  = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned STS_BIT = 5;
  localparam int unsigned CFG_W  = 5;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [POS_W:0]   wpos_t;

  // Per-axis timing set as software stored it (encoding untouched).
  typedef struct packed {
    pos_t last;     // total minus one
    pos_t de_last;  // active minus one
    pos_t sync_a;   // sync start field (axis-specific encoding)
    pos_t sync_b;   // sync end field (raw)
  } axis_cfg_t;

  typedef struct packed {
    logic sts;
    logic ien;
    logic ilace;
    logic vneg;
    logic hneg;
    logic run;
  } ctrl_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_DRIVE = 3'd1,
    A_HEXT  = 3'd2,
    A_HSYN  = 3'd3,
    A_VEXT  = 3'd4,
    A_VSYN  = 3'd5
  } reg_addr_e;

  function automatic wpos_t widen(input pos_t v);
    return {1'b0, v};
  endfunction

  function automatic wpos_t plus_one(input pos_t v);
    return {1'b0, v} + wpos_t'(1);
  endfunction

  // Half-open window [lo, hi) on a widened scale.
  function automatic logic in_span(input pos_t p, input wpos_t lo, input wpos_t hi);
    return (widen(p) >= lo) && (widen(p) < hi);
  endfunction

  // Active region 0..last_m1 inclusive.
  function automatic logic in_active(input pos_t p, input pos_t last_m1);
    return p <= last_m1;
  endfunction

  function automatic logic [DATA_W-1:0] pack_pair(input pos_t lo, input pos_t hi);
    logic [DATA_W-1:0] r;
    r = '0;
    r[POS_W-1:0]       = lo;
    r[HI_LSB +: POS_W] = hi;
    return r;
  endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              vbl_set,
  output ctrl_t             ctrl,
  output logic              dac_en,
  output axis_cfg_t         hcfg,
  output axis_cfg_t         vcfg
);

  logic [CFG_W-1:0] cfg_q;
  logic             sts_q;
  logic             drive_q;
  axis_cfg_t        hcfg_q, vcfg_q;
  reg_addr_e        sel;
  logic             ctrl_wr;
  logic             sts_clr;
  logic             unused_wbits;

  assign sel     = reg_addr_e'(addr);
  assign ctrl_wr = wr_en && (sel == A_CTRL);
  assign sts_clr = ctrl_wr && wdata[STS_BIT];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      drive_q <= 1'b0;
      hcfg_q  <= '0;
      vcfg_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        A_CTRL:  cfg_q   <= wdata[CFG_W-1:0];
        A_DRIVE: drive_q <= wdata[0];
        A_HEXT: begin
          hcfg_q.last    <= wdata[POS_W-1:0];
          hcfg_q.de_last <= wdata[HI_LSB +: POS_W];
        end
        A_HSYN: begin
          hcfg_q.sync_a <= wdata[POS_W-1:0];
          hcfg_q.sync_b <= wdata[HI_LSB +: POS_W];
        end
        A_VEXT: begin
          vcfg_q.last    <= wdata[POS_W-1:0];
          vcfg_q.de_last <= wdata[HI_LSB +: POS_W];
        end
        A_VSYN: begin
          vcfg_q.sync_a <= wdata[POS_W-1:0];
          vcfg_q.sync_b <= wdata[HI_LSB +: POS_W];
        end
        default: ;
      endcase
    end
  end

  // Status: a set event wins over a simultaneous write-one clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts_q <= 1'b0;
    else if (vbl_set) sts_q <= 1'b1;
    else if (sts_clr) sts_q <= 1'b0;
  end

  assign ctrl   = {sts_q, cfg_q};
  assign dac_en = drive_q;
  assign hcfg   = hcfg_q;
  assign vcfg   = vcfg_q;

  always_comb begin
    rdata = '0;
    case (sel)
      A_CTRL:  rdata = DATA_W'(ctrl);
      A_DRIVE: rdata = DATA_W'(drive_q);
      A_HEXT:  rdata = pack_pair(hcfg_q.last,   hcfg_q.de_last);
      A_HSYN:  rdata = pack_pair(hcfg_q.sync_a, hcfg_q.sync_b);
      A_VEXT:  rdata = pack_pair(vcfg_q.last,   vcfg_q.de_last);
      A_VSYN:  rdata = pack_pair(vcfg_q.sync_a, vcfg_q.sync_b);
      default: rdata = '0;
    endcase
  end

  assert_sts_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_set |=> ctrl.sts);

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !vbl_set) |=> !ctrl.sts);

  assert_sts_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_clr && !vbl_set) |=> (ctrl.sts == $past(ctrl.sts)));

endmodule

// File: rtl/raster_axis.sv
module raster_axis
  import raster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic adv,
  input  pos_t last,
  output pos_t cnt,
  output logic wrap
);

  pos_t cnt_q;

  // >= rather than == so that shrinking the total mid-frame cannot run away.
  assign wrap = en && adv && (cnt_q >= last);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!en)  cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_q + pos_t'(1);
  end

  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && !wrap) |=> (cnt == pos_t'($past(cnt) + pos_t'(1))));

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/raster_out.sv
module raster_out
  import raster_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctrl_t     ctrl,
  input  logic      dac_en,
  input  axis_cfg_t hcfg,
  input  axis_cfg_t vcfg,
  input  pos_t      hcnt,
  input  pos_t      vcnt,
  output logic      de_o,
  output logic      hsync_o,
  output logic      vsync_o
);

  logic drive;
  logic h_act, v_act;
  logic hs_win, vs_win;
  logic unused_cfg;

  assign unused_cfg = ^{ctrl.sts, ctrl.ien, ctrl.ilace, hcfg.last, vcfg.last};

  assign drive  = ctrl.run && dac_en;
  assign h_act  = in_active(hcnt, hcfg.de_last);
  assign v_act  = in_active(vcnt, vcfg.de_last);
  // Horizontal start is stored minus one; vertical start is raw.
  assign hs_win = in_span(hcnt, plus_one(hcfg.sync_a), widen(hcfg.sync_b));
  assign vs_win = in_span(vcnt, widen(vcfg.sync_a),    widen(vcfg.sync_b));

  assign de_o    = drive && h_act && v_act;
  assign hsync_o = (drive && hs_win) ^ ctrl.hneg;
  assign vsync_o = (drive && vs_win) ^ ctrl.vneg;

  assert_idle_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> (!de_o && (hsync_o == ctrl.hneg) && (vsync_o == ctrl.vneg)));

  assert_de_needs_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> dac_en);

  assert_sync_idle_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_en |-> ((hsync_o == ctrl.hneg) && (vsync_o == ctrl.vneg)));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              irq_o
);

  ctrl_t     ctrl;
  logic      dac_en;
  axis_cfg_t hcfg, vcfg;
  pos_t      hcnt, vcnt;
  logic      line_end;   // horizontal wrap event
  logic      frame_end;  // vertical wrap event
  logic      vbl_set;    // first line after the active region begins
  logic      field_q;

  raster_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .vbl_set (vbl_set),
    .ctrl    (ctrl),
    .dac_en  (dac_en),
    .hcfg    (hcfg),
    .vcfg    (vcfg)
  );

  raster_axis u_hcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctrl.run),
    .adv   (1'b1),
    .last  (hcfg.last),
    .cnt   (hcnt),
    .wrap  (line_end)
  );

  raster_axis u_vcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctrl.run),
    .adv   (line_end),
    .last  (vcfg.last),
    .cnt   (vcnt),
    .wrap  (frame_end)
  );

  raster_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .dac_en  (dac_en),
    .hcfg    (hcfg),
    .vcfg    (vcfg),
    .hcnt    (hcnt),
    .vcnt    (vcnt),
    .de_o    (de_o),
    .hsync_o (hsync_o),
    .vsync_o (vsync_o)
  );

  assign vbl_set = line_end && (vcnt == vcfg.de_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      field_q <= 1'b0;
    else if (!ctrl.run || !ctrl.ilace) field_q <= 1'b0;
    else if (frame_end)              field_q <= ~field_q;
  end

  assign field_o = field_q;
  assign irq_o   = ctrl.sts && ctrl.ien;

  assert_field_toggles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ctrl.run && ctrl.ilace) |=> (field_o != $past(field_o)));

  assert_field_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && ctrl.run && ctrl.ilace) |=> $stable(field_o));

  assert_no_set_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> !vbl_set);

endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;

  localparam logic [31:0] RUN = 32'h01, HNEG = 32'h02, VNEG = 32'h04;
  localparam logic [31:0] ILACE = 32'h08, IEN = 32'h10, STS = 32'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        de_o, hsync_o, vsync_o, field_o, irq_o;

  int tests_run = 0;
  int tests_failed = 0;

  always #2 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .de_o (de_o),
    .hsync_o (hsync_o), .vsync_o (vsync_o), .field_o (field_o), .irq_o (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns one negedge later.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = '0;
  endtask

  function automatic logic [31:0] pair(input int lo, input int hi);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  // Stop, clear status, program human-unit timing, set drive, then run.
  // On return the current cycle has pixel 0 of line 0.
  task automatic start(input int ht, ha, hss, hse, vt, va, vss, vse,
                       input logic [31:0] cbits, input bit drive);
    wr(3'd0, STS);
    wr(3'd2, pair(ht - 1, ha - 1));
    wr(3'd3, pair(hss - 1, hse));
    wr(3'd4, pair(vt - 1, va - 1));
    wr(3'd5, pair(vss, vse));
    wr(3'd1, 32'(drive));
    wr(3'd0, cbits | RUN);
  endtask

  task automatic scan(input string lbl, input int ht, ha, hss, hse, vt, va, vss, vse,
                      input bit hn, input bit vn);
    int ede, ehs, evs;
    ede = 0; ehs = 0; evs = 0;
    start(ht, ha, hss, hse, vt, va, vss, vse, (hn ? HNEG : 0) | (vn ? VNEG : 0), 1'b1);
    for (int i = 0; i < 2 * ht * vt; i++) begin
      int h, v;
      h = i % ht;
      v = (i / ht) % vt;
      if (de_o !== ((h < ha) && (v < va))) ede++;
      if (hsync_o !== (((h >= hss) && (h < hse)) ^ hn)) ehs++;
      if (vsync_o !== (((v >= vss) && (v < vse)) ^ vn)) evs++;
      @(negedge clk);
    end
    chk({"R3 de window ", lbl}, ede, 0);
    chk({"R2 R4 hsync position ", lbl}, ehs, 0);
    chk({"R5 vsync position ", lbl}, evs, 0);
    if (hn || vn) chk({"R6 inverted polarity ", lbl}, ehs + evs, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R12 de after reset", de_o, 0);
    chk("R12 hsync after reset", hsync_o, 0);
    chk("R12 vsync after reset", vsync_o, 0);
    chk("R12 irq after reset", irq_o, 0);
    chk("R12 field after reset", field_o, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R12 register zero after reset", d, 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(3'd2, 32'h0ABC_0123); rd(3'd2, d); chk("R1 hext readback", d, 32'h0ABC_0123);
    wr(3'd3, 32'h0456_0789); rd(3'd3, d); chk("R1 hsync readback", d, 32'h0456_0789);
    wr(3'd4, 32'h0001_0FFE); rd(3'd4, d); chk("R1 vext readback", d, 32'h0001_0FFE);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, d); chk("R1 vsync unused bits zero", d, 32'h0FFF_0FFF);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R1 drive readback", d, 32'h1);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hFFFF_FFFE); rd(3'd0, d); chk("R1 control readback", d, 32'h1E);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_vblank();
    logic [31:0] d;
    start(10, 6, 7, 9, 8, 5, 6, 7, 0, 1'b1);
    repeat (49) @(negedge clk);
    rd(3'd0, d); chk("R7 status clear before blank line", d[5], 0);
    @(negedge clk);
    rd(3'd0, d); chk("R7 status set on first blank line", d[5], 1);
    chk("R7 irq gated off by enable", irq_o, 0);
    wr(3'd0, RUN | IEN);
    chk("R7 irq follows enable", irq_o, 1);
    wr(3'd0, RUN | IEN);
    rd(3'd0, d); chk("R8 write zero keeps status", d[5], 1);
    wr(3'd0, RUN | IEN | STS);
    rd(3'd0, d); chk("R8 write one clears status", d[5], 0);
    chk("R8 irq drops after clear", irq_o, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int bad;
    bad = 0;
    start(10, 6, 7, 9, 8, 5, 6, 7, 0, 1'b1);
    repeat (23) @(negedge clk);
    wr(3'd0, HNEG | STS);
    for (int i = 0; i < 100; i++) begin
      if (de_o !== 1'b0 || hsync_o !== 1'b1 || vsync_o !== 1'b0) bad++;
      @(negedge clk);
    end
    chk("R9 outputs idle while stopped", bad, 0);
    rd(3'd0, d); chk("R9 status cannot set while stopped", d[5], 0);
    wr(3'd0, RUN);
    chk("R9 restart from pixel 0 de", de_o, 1);
    repeat (6) @(negedge clk);
    chk("R9 restart pixel 6 de low", de_o, 0);
  endtask

  task automatic t_drive_off();
    logic [31:0] d;
    int bad;
    bad = 0;
    start(10, 6, 7, 9, 8, 5, 6, 7, 0, 1'b0);
    for (int i = 0; i < 80; i++) begin
      if (de_o !== 1'b0 || hsync_o !== 1'b0 || vsync_o !== 1'b0) bad++;
      if (i == 50) begin
        rd(3'd0, d);
        chk("R10 status still sets without drive", d[5], 1);
      end
      @(negedge clk);
    end
    chk("R10 outputs silent without drive", bad, 0);
  endtask

  task automatic t_interlace();
    int bad;
    bad = 0;
    start(10, 6, 7, 9, 8, 5, 6, 7, ILACE, 1'b1);
    for (int i = 0; i < 170; i++) begin
      if (field_o !== 1'((i / 80) % 2)) bad++;
      @(negedge clk);
    end
    chk("R11 field toggles per frame", bad, 0);
    bad = 0;
    wr(3'd0, RUN);
    for (int i = 0; i < 170; i++) begin
      if (field_o !== 1'b0) bad++;
      @(negedge clk);
    end
    chk("R11 field low without interlace", bad, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    scan("timing A positive", 10, 6, 7, 9, 8, 5, 6, 7, 1'b0, 1'b0);
    scan("timing A negative", 10, 6, 7, 9, 8, 5, 6, 7, 1'b1, 1'b1);
    scan("timing B positive", 16, 12, 13, 15, 6, 3, 4, 6, 1'b0, 1'b0);
    t_vblank();
    t_stop();
    t_drive_off();
    t_interlace();
    summary();
  end

endmodule